// File: doc/BRIEF.md
# Bridge Downstream Window Filter

This block holds the downstream address windows of a PCI-to-PCI bridge: one I/O window, one non-prefetchable memory window and one prefetchable memory window, each held as a base and a limit. It also holds the two command enables that gate I/O and memory decoding. Software programs all of these through a byte-enabled, dword-addressed configuration write port.

Two query ports use the windows. The clip port takes a region, given as a start, a size and a space type. One cycle later it returns the part of that region that lies inside the matching window. This part may be smaller than the request and may not be aligned. When nothing of the region lies inside, the port returns an unmapped marker. The hit port answers in the same cycle whether one address falls inside the window for its space.

A one-cycle change pulse follows any write that touches window bytes. A caller can use it to re-run its region mappings.

Top module: `bridge_window_filter`

## Requirements
- R1: After reset, every register holds zero and both command enables are clear. `rsp_valid`, `win_chg` and `hit` are low, and every request returns unmapped.
- R2: The I/O window base is built from the I/O base byte. Bits 7:4 of that byte become address bits 15:12, and the low 12 address bits are zero. The I/O limit is built the same way from the I/O limit byte, with the low 12 address bits forced to ones. Bit 0 of the base byte makes the base 32-bit, with its upper 16-bit register supplying address bits 31:16; bit 0 of the limit byte does the same for the limit. When that bit is clear, address bits 31:16 are zero. Address bits 63:32 are always zero.
- R3: The memory base and limit each come from a 16-bit register. Register bits 15:4 become address bits 31:20, and register bits 3:0 are ignored. The base has its low 20 bits zero and the limit has its low 20 bits forced to ones. Address bits 63:32 are zero.
- R4: The prefetchable base and limit are built as in R3. In addition, each has its own 32-bit upper register that supplies address bits 63:32.
- R5: `req_io=1` selects the I/O window, and `req_pf` is then ignored. Otherwise `req_pf=1` selects the prefetchable window and `req_pf=0` selects the memory window. The hit port selects its window the same way, using `hit_io` and `hit_pf`.
- R6: The command enables sit in the dword at offset 0x04, byte 0: bit 0 enables I/O and bit 1 enables memory. A request or hit in a space whose enable is clear is unmapped, and `hit` stays 0.
- R7: The clipped start is the larger of the request start and the window base. The clipped end is the smaller of the request end (start + size − 1) and the window limit. The request end is computed without wrapping past 2^64. The output size is end − start + 1.
- R8: When the clipped start exceeds the clipped end, or the request size is zero, the output is unmapped: `rsp_addr` is all ones and `rsp_size` is zero.
- R9: Each cycle with `req_valid` high yields exactly one cycle of `rsp_valid` on the next cycle. The result uses the registers as they stood in the request cycle.
- R10: `hit` is combinational. It is high when the space is enabled and base ≤ `hit_addr` ≤ limit.
- R11: Write map, by byte offset:
  - 0x1C: I/O base byte
  - 0x1D: I/O limit byte
  - 0x20–0x21: memory base
  - 0x22–0x23: memory limit
  - 0x24–0x25: prefetchable base
  - 0x26–0x27: prefetchable limit
  - 0x28: prefetchable base upper 32 bits
  - 0x2C: prefetchable limit upper 32 bits
  - 0x30–0x31: I/O base upper 16 bits
  - 0x32–0x33: I/O limit upper 16 bits

  Only bytes whose enable is set change. All other bytes are discarded.
- R12: `win_chg` pulses for one cycle, in the cycle after a write with at least one enabled byte at 0x1C–0x1D or 0x20–0x33. No other write raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Byte offset of the write; bits 1:0 are ignored |
| cfg_be | input | 4 | Byte enables of the dword |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Clip request strobe |
| req_io | input | 1 | Request is in I/O space |
| req_pf | input | 1 | Memory request is prefetchable |
| req_addr | input | 64 | Region start |
| req_size | input | 64 | Region size in bytes |
| rsp_valid | output | 1 | Clip result strobe |
| rsp_addr | output | 64 | Clipped start, all ones when unmapped |
| rsp_size | output | 64 | Clipped size, zero when unmapped |
| win_chg | output | 1 | Window registers changed |
| hit_io | input | 1 | Hit query is in I/O space |
| hit_pf | input | 1 | Hit query is prefetchable |
| hit_addr | input | 64 | Address to test |
| hit | output | 1 | Address lies inside an enabled window |

## Verification
The bench sends regions that straddle the lower edge of a window, straddle its upper edge, or lie wholly outside it. A design that only tested for a hit, instead of intersecting, would return the unclipped region. Other cases check the I/O 32-bit flag both on and off, and write non-zero low nibbles that must be masked. A decode that used the wrong bits would move the window, and hit tests on each side of its edges would show it. A prefetchable region ending at the top of the 64-bit space catches an end computation that wraps. Writes that enable only status bytes, or only the command byte, must leave the windows and the change pulse untouched.

// File: rtl/bridge_window_filter.sv
module bridge_window_filter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  input  logic        req_io,
  input  logic        req_pf,
  input  logic [63:0] req_addr,
  input  logic [63:0] req_size,
  output logic        rsp_valid,
  output logic [63:0] rsp_addr,
  output logic [63:0] rsp_size,
  output logic        win_chg,
  input  logic        hit_io,
  input  logic        hit_pf,
  input  logic [63:0] hit_addr,
  output logic        hit
);

  localparam logic [5:0] DW_CMD  = 6'h01;
  localparam logic [5:0] DW_IO   = 6'h07;
  localparam logic [5:0] DW_MEM  = 6'h08;
  localparam logic [5:0] DW_PF   = 6'h09;
  localparam logic [5:0] DW_PFBH = 6'h0A;
  localparam logic [5:0] DW_PFLH = 6'h0B;
  localparam logic [5:0] DW_IOHI = 6'h0C;

  logic [7:0]  io_base_q, io_lim_q;
  logic [15:0] io_base_hi_q, io_lim_hi_q;
  logic [15:0] mem_base_q, mem_lim_q, pf_base_q, pf_lim_q;
  logic [31:0] pf_base_hi_q, pf_lim_hi_q;
  logic        io_en_q, mem_en_q;

  wire [5:0] dw = cfg_addr[7:2];

  // configuration writes, byte by byte
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_base_q    <= '0;
      io_lim_q     <= '0;
      io_base_hi_q <= '0;
      io_lim_hi_q  <= '0;
      mem_base_q   <= '0;
      mem_lim_q    <= '0;
      pf_base_q    <= '0;
      pf_lim_q     <= '0;
      pf_base_hi_q <= '0;
      pf_lim_hi_q  <= '0;
      io_en_q      <= 1'b0;
      mem_en_q     <= 1'b0;
    end else if (cfg_we) begin
      case (dw)
        DW_CMD: if (cfg_be[0]) begin
          io_en_q  <= cfg_wdata[0];
          mem_en_q <= cfg_wdata[1];
        end
        DW_IO: begin
          if (cfg_be[0]) io_base_q <= cfg_wdata[7:0];
          if (cfg_be[1]) io_lim_q  <= cfg_wdata[15:8];
        end
        DW_MEM: begin
          if (cfg_be[0]) mem_base_q[7:0]  <= cfg_wdata[7:0];
          if (cfg_be[1]) mem_base_q[15:8] <= cfg_wdata[15:8];
          if (cfg_be[2]) mem_lim_q[7:0]   <= cfg_wdata[23:16];
          if (cfg_be[3]) mem_lim_q[15:8]  <= cfg_wdata[31:24];
        end
        DW_PF: begin
          if (cfg_be[0]) pf_base_q[7:0]  <= cfg_wdata[7:0];
          if (cfg_be[1]) pf_base_q[15:8] <= cfg_wdata[15:8];
          if (cfg_be[2]) pf_lim_q[7:0]   <= cfg_wdata[23:16];
          if (cfg_be[3]) pf_lim_q[15:8]  <= cfg_wdata[31:24];
        end
        DW_PFBH: for (int b = 0; b < 4; b++)
          if (cfg_be[b]) pf_base_hi_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
        DW_PFLH: for (int b = 0; b < 4; b++)
          if (cfg_be[b]) pf_lim_hi_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
        DW_IOHI: begin
          if (cfg_be[0]) io_base_hi_q[7:0]  <= cfg_wdata[7:0];
          if (cfg_be[1]) io_base_hi_q[15:8] <= cfg_wdata[15:8];
          if (cfg_be[2]) io_lim_hi_q[7:0]   <= cfg_wdata[23:16];
          if (cfg_be[3]) io_lim_hi_q[15:8]  <= cfg_wdata[31:24];
        end
        default: ;
      endcase
    end
  end

  // change pulse
  wire touch = cfg_we &&
               ((dw == DW_IO && |cfg_be[1:0]) ||
                (dw >= DW_MEM && dw <= DW_IOHI && |cfg_be));

  always_ff @(posedge clk) begin
    if (!rst_n) win_chg <= 1'b0;
    else        win_chg <= touch;
  end

  // window decode
  wire [63:0] io_lo  = {32'h0, io_base_q[0] ? io_base_hi_q : 16'h0, io_base_q[7:4], 12'h000};
  wire [63:0] io_hi  = {32'h0, io_lim_q[0]  ? io_lim_hi_q  : 16'h0, io_lim_q[7:4],  12'hFFF};
  wire [63:0] mem_lo = {32'h0, mem_base_q[15:4], 20'h00000};
  wire [63:0] mem_hi = {32'h0, mem_lim_q[15:4],  20'hFFFFF};
  wire [63:0] pf_lo  = {pf_base_hi_q, pf_base_q[15:4], 20'h00000};
  wire [63:0] pf_hi  = {pf_lim_hi_q,  pf_lim_q[15:4],  20'hFFFFF};

  logic [63:0] rq_lo, rq_hi, hq_lo, hq_hi;
  logic        rq_en, hq_en;

  always_comb begin
    if (req_io) begin
      rq_lo = io_lo;  rq_hi = io_hi;  rq_en = io_en_q;
    end else if (req_pf) begin
      rq_lo = pf_lo;  rq_hi = pf_hi;  rq_en = mem_en_q;
    end else begin
      rq_lo = mem_lo; rq_hi = mem_hi; rq_en = mem_en_q;
    end
  end

  always_comb begin
    if (hit_io) begin
      hq_lo = io_lo;  hq_hi = io_hi;  hq_en = io_en_q;
    end else if (hit_pf) begin
      hq_lo = pf_lo;  hq_hi = pf_hi;  hq_en = mem_en_q;
    end else begin
      hq_lo = mem_lo; hq_hi = mem_hi; hq_en = mem_en_q;
    end
  end

  assign hit = hq_en && hit_addr >= hq_lo && hit_addr <= hq_hi;

  // region clip
  wire [64:0] rq_end = {1'b0, req_addr} + {1'b0, req_size} - 65'd1;
  wire [63:0] c_start = (req_addr > rq_lo) ? req_addr : rq_lo;
  wire [64:0] c_end65 = (rq_end < {1'b0, rq_hi}) ? rq_end : {1'b0, rq_hi};
  wire [63:0] c_end = c_end65[63:0];
  wire        c_ok = rq_en && (req_size != 64'd0) && (c_start <= c_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '1;
      rsp_size  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr <= c_ok ? c_start : '1;
        rsp_size <= c_ok ? (c_end - c_start + 64'd1) : '0;
      end
    end
  end

  // R9
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R9
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R8
  unmapped_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_size == 64'd0) |-> rsp_addr == '1);
  // R7
  clip_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_size == 64'd0 ||
                   (rsp_addr >= $past(req_addr) && rsp_size <= $past(req_size))));
  // R6
  io_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_io && !io_en_q) |=> rsp_size == 64'd0);
  // R12
  chg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_chg |-> $past(cfg_we));
  // R10
  hit_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hit_io) |-> io_en_q);

endmodule

// File: tb/bridge_window_filter_tb.sv
module bridge_window_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_io = 1'b0, req_pf = 1'b0;
  logic [63:0] req_addr = '0, req_size = '0;
  logic        rsp_valid, win_chg, hit;
  logic [63:0] rsp_addr, rsp_size;
  logic        hit_io = 1'b0, hit_pf = 1'b0;
  logic [63:0] hit_addr = '0;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [63:0] UNM = 64'hFFFF_FFFF_FFFF_FFFF;

  always #4 clk = ~clk;

  bridge_window_filter u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_io(req_io), .req_pf(req_pf),
    .req_addr(req_addr), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_size(rsp_size),
    .win_chg(win_chg),
    .hit_io(hit_io), .hit_pf(hit_pf), .hit_addr(hit_addr), .hit(hit)
  );

  task automatic check(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [7:0] a, logic [31:0] d, logic [3:0] be, bit exp_chg);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R12 win_chg", {63'd0, win_chg}, {63'd0, exp_chg});
    @(negedge clk);
    check("R12 win_chg one cycle", {63'd0, win_chg}, 64'd0);
  endtask

  task automatic clip(string rq, bit io, bit pf, logic [63:0] a, logic [63:0] s,
                      logic [63:0] ea, logic [63:0] es);
    @(negedge clk);
    req_valid = 1'b1; req_io = io; req_pf = pf; req_addr = a; req_size = s;
    @(negedge clk);
    req_valid = 1'b0;
    check({rq, " R9 rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
    check({rq, " addr"}, rsp_addr, ea);
    check({rq, " size"}, rsp_size, es);
    @(negedge clk);
    check("R9 rsp_valid drops", {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic probe(string rq, bit io, bit pf, logic [63:0] a, bit exp);
    @(negedge clk);
    hit_io = io; hit_pf = pf; hit_addr = a;
    #1;
    check(rq, {63'd0, hit}, {63'd0, exp});
  endtask

  task automatic t_reset;
    check("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check("R1 win_chg", {63'd0, win_chg}, 64'd0);
    probe("R1 hit off", 1'b0, 1'b0, 64'h0, 1'b0);
    clip("R1 mem off", 1'b0, 1'b0, 64'h10, 64'h10, UNM, 64'd0);
    clip("R1 io off", 1'b1, 1'b0, 64'h0, 64'h10, UNM, 64'd0);
  endtask

  task automatic t_mem;
    cfg_wr(8'h04, 32'h3, 4'h1, 1'b0);
    clip("R3 default window", 1'b0, 1'b0, 64'h10, 64'h10, 64'h10, 64'h10);
    cfg_wr(8'h20, 32'h1250_123A, 4'hF, 1'b1);
    clip("R7 low edge", 1'b0, 1'b0, 64'h1220_0000, 64'h20_0000, 64'h1230_0000, 64'h10_0000);
    clip("R7 high edge", 1'b0, 1'b0, 64'h1250_0000, 64'h20_0000, 64'h1250_0000, 64'h10_0000);
    clip("R7 inner", 1'b0, 1'b0, 64'h1240_0004, 64'h3, 64'h1240_0004, 64'h3);
    clip("R8 outside", 1'b0, 1'b0, 64'h2000_0000, 64'h100, UNM, 64'd0);
    clip("R8 size zero", 1'b0, 1'b0, 64'h1240_0000, 64'h0, UNM, 64'd0);
    probe("R3 base masked", 1'b0, 1'b0, 64'h1230_0000, 1'b1);
    probe("R3 below base", 1'b0, 1'b0, 64'h122F_FFFF, 1'b0);
    probe("R3 limit ones", 1'b0, 1'b0, 64'h125F_FFFF, 1'b1);
    probe("R3 above limit", 1'b0, 1'b0, 64'h1260_0000, 1'b0);
    clip("R5 pf selects pf window", 1'b0, 1'b1, 64'h1230_0000, 64'h100, UNM, 64'd0);
  endtask

  task automatic t_pf;
    cfg_wr(8'h24, 32'h4010_4000, 4'hF, 1'b1);
    cfg_wr(8'h28, 32'h1, 4'hF, 1'b1);
    cfg_wr(8'h2C, 32'h1, 4'hF, 1'b1);
    clip("R4 pf clip", 1'b0, 1'b1, 64'h1_4010_0000, 64'h20_0000, 64'h1_4010_0000, 64'h10_0000);
    clip("R5 non-pf misses pf", 1'b0, 1'b0, 64'h1_4010_0000, 64'h20_0000, UNM, 64'd0);
    probe("R4 pf base", 1'b0, 1'b1, 64'h1_4000_0000, 1'b1);
    probe("R4 pf below", 1'b0, 1'b1, 64'h0_4000_0000, 1'b0);
    cfg_wr(8'h24, 32'hFFF0_FFF0, 4'hF, 1'b1);
    cfg_wr(8'h28, 32'hFFFF_FFFF, 4'hF, 1'b1);
    cfg_wr(8'h2C, 32'hFFFF_FFFF, 4'hF, 1'b1);
    clip("R7 no wrap at top", 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FF00, 64'h200,
         64'hFFFF_FFFF_FFFF_FF00, 64'h100);
  endtask

  task automatic t_io;
    cfg_wr(8'h1C, 32'hABCD_3121, 4'h3, 1'b1);
    cfg_wr(8'h30, 32'h0001_0001, 4'hF, 1'b1);
    clip("R2 io 32-bit clip", 1'b1, 1'b1, 64'h1_1000, 64'h2000, 64'h1_2000, 64'h1000);
    probe("R2 io limit", 1'b1, 1'b0, 64'h1_3FFF, 1'b1);
    probe("R2 io past limit", 1'b1, 1'b0, 64'h1_4000, 1'b0);
    cfg_wr(8'h1C, 32'h0000_3020, 4'h3, 1'b1);
    probe("R2 io 16-bit base", 1'b1, 1'b0, 64'h2000, 1'b1);
    probe("R2 upper ignored", 1'b1, 1'b0, 64'h1_2000, 1'b0);
    cfg_wr(8'h1C, 32'h5555_0000, 4'hC, 1'b0);
    probe("R11 status bytes ignored", 1'b1, 1'b0, 64'h2000, 1'b1);
    cfg_wr(8'h1C, 32'h0000_0040, 4'h1, 1'b1);
    clip("R8 base above limit", 1'b1, 1'b0, 64'h2000, 64'h100, UNM, 64'd0);
    probe("R11 limit byte kept", 1'b1, 1'b0, 64'h3FFF, 1'b0);
    cfg_wr(8'h1C, 32'h0000_0020, 4'h1, 1'b1);
    clip("R2 io restored", 1'b1, 1'b0, 64'h3F00, 64'h200, 64'h3F00, 64'h100);
  endtask

  task automatic t_enables;
    cfg_wr(8'h04, 32'h2, 4'h1, 1'b0);
    clip("R6 io disabled", 1'b1, 1'b0, 64'h2000, 64'h100, UNM, 64'd0);
    probe("R6 io hit disabled", 1'b1, 1'b0, 64'h2000, 1'b0);
    clip("R6 mem still on", 1'b0, 1'b0, 64'h1240_0000, 64'h10, 64'h1240_0000, 64'h10);
    cfg_wr(8'h04, 32'h1, 4'h1, 1'b0);
    clip("R6 mem disabled", 1'b0, 1'b0, 64'h1240_0000, 64'h10, UNM, 64'd0);
    probe("R10 io back on", 1'b1, 1'b0, 64'h2000, 1'b1);
    cfg_wr(8'h34, 32'hFFFF_FFFF, 4'hF, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem();
    t_pf();
    t_io();
    t_enables();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule